// File: doc/BRIEF.md
# Streaming Adler-32 Checksum Engine

This unit computes the Adler-32 checksum of a byte stream, taking at most one byte per clock on a valid/ready handshake. It keeps two running sums: the low sum is one plus every byte seen so far, and the high sum adds up every value the low sum has taken. Both are taken modulo 65521, the largest prime below 2^16. The unit avoids an exact modulo on every byte. It keeps each sum in a 32-bit register and, after each accepted byte, shrinks it with a cheap congruent fold based on 2^16 ≡ 15 (mod 65521): `low16(x) + 15 * (x >> 16)`. That fold keeps the value bounded, but it does not always bring it below the modulus.

The exact reduction is done once per message. After the byte flagged as last has been accepted, the unit spends one cycle with the input stalled. In that cycle it folds each sum twice and subtracts the modulus at most once. It then registers the 32-bit checksum and raises a one-cycle done pulse. The sums then return to their initial values, so the next message can follow without any other action. A clear input throws away a message that is only partly received and loads the checksum of an empty message.

Top module: `adler_stream_unit`

## Requirements
- R1: After reset, and in the cycle after a cycle with `clear` high, `sum_out` reads 0x00000001 (the checksum of an empty message) and `sum_done` is low. After reset, `in_ready` is high.
- R2: For a message of bytes d1..dn (n ≥ 1), with A = (1 + Σ di) mod 65521 and B = Σ over k of (1 + d1 + … + dk), taken mod 65521, `sum_out` equals B in bits 31:16 and A in bits 15:0 while `sum_done` is high.
- R3: While `sum_done` is high, both 16-bit halves of `sum_out` are below 65521.
- R4: Both internal sums always stay below 2^17, whatever the message length. The checksum is still exact after thousands of consecutive 0xFF bytes.
- R5: `sum_done` is a single-cycle pulse. It is registered at the first rising edge after the edge that accepts the last byte, and only if `clear` is low in between. `sum_out` keeps its value until the next pulse or the next clear.
- R6: `in_ready` is low for exactly the one cycle that follows acceptance of a byte with `in_last` high. Otherwise it is high, except while `clear` is high.
- R7: When `in_valid` is low, `in_byte` and `in_last` are ignored. Idle cycles inside a message do not change its checksum.
- R8: `clear` wins over everything else. It holds `in_ready` low, so no byte is accepted in that cycle, it cancels any pending completion, and it discards the partial sums. The next message starts from A = 1 and B = 0.
- R9: After a done pulse, the next message starts from A = 1 and B = 0 with no clear needed, so messages can be sent back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Discards the current message and restarts both sums |
| in_valid | input | 1 | A byte is offered on `in_byte` |
| in_ready | output | 1 | The engine can accept a byte this cycle |
| in_byte | input | 8 | Message byte |
| in_last | input | 1 | Marks the final byte of the message |
| sum_out | output | 32 | Checksum: high sum in bits 31:16, low sum in bits 15:0 |
| sum_done | output | 1 | One-cycle pulse when `sum_out` holds a new checksum |

## Verification
Some properties are checked on every cycle. The assertions check that both folded sums stay below 2^17, that the finishing reduction leaves nothing above the low sixteen bits, that each half of a reported checksum is below the modulus, and that the handshake timing holds: a stall right after the last byte, a done pulse on the following edge, single-cycle pulses, a result held between events, and clear taking priority. Exact arithmetic can only be shown by the bench's scenarios, which compare against a step-by-step modular reference. These include empty and single-byte messages, long runs of 0xFF and 0x00, random messages with idle gaps carrying junk data, back-to-back messages, and a message abandoned by a clear.

// File: rtl/adler_lazy_pkg.sv
package adler_lazy_pkg;
    // Default geometry of the engine.
    localparam int ACC_W_DEF  = 32;     // accumulator width
    localparam int HALF_W_DEF = 16;     // width of each checksum half
    localparam int DATA_W_DEF = 8;      // one byte per beat
    localparam int MOD_DEF    = 65521;  // largest prime below 2^16

    // 2^HALF_W modulo the prime: the weight given to the bits above HALF_W by a fold.
    function automatic int fold_weight(input int half_w, input int modulus);
        return (1 << half_w) - modulus;
    endfunction
endpackage

// File: rtl/adler_fold.sv
// Congruent partial reduction: low half plus weight times the high part.
module adler_fold #(
    parameter int W      = 32,
    parameter int HALF_W = 16,
    parameter int WEIGHT = 15
) (
    input  logic [W-1:0] value,
    output logic [W-1:0] folded
);
    localparam logic [W-1:0] WEIGHT_V = W'(WEIGHT);

    logic [W-1:0] low_part;
    logic [W-1:0] high_part;

    always_comb begin
        low_part  = W'(value[HALF_W-1:0]);
        high_part = W'(value[W-1:HALF_W]);
        folded    = low_part + WEIGHT_V * high_part;
    end
endmodule

// File: rtl/adler_step.sv
// One byte of Adler-32 update on lazily reduced sums.
module adler_step #(
    parameter int ACC_W  = 32,
    parameter int HALF_W = 16,
    parameter int DATA_W = 8,
    parameter int WEIGHT = 15
) (
    input  logic [ACC_W-1:0]  a_cur,
    input  logic [ACC_W-1:0]  b_cur,
    input  logic [DATA_W-1:0] data,
    output logic [ACC_W-1:0]  a_next,
    output logic [ACC_W-1:0]  b_next
);
    logic [ACC_W-1:0] a_raw;
    logic [ACC_W-1:0] b_raw;

    always_comb begin
        a_raw = a_cur + ACC_W'(data);
        b_raw = b_cur + a_raw;
    end

    adler_fold #(.W(ACC_W), .HALF_W(HALF_W), .WEIGHT(WEIGHT)) u_fold_a (
        .value  (a_raw),
        .folded (a_next)
    );

    adler_fold #(.W(ACC_W), .HALF_W(HALF_W), .WEIGHT(WEIGHT)) u_fold_b (
        .value  (b_raw),
        .folded (b_next)
    );
endmodule

// File: rtl/adler_reduce.sv
// Exact reduction: two folds, then at most one subtraction of the modulus.
module adler_reduce #(
    parameter int W       = 32,
    parameter int HALF_W  = 16,
    parameter int MODULUS = 65521,
    parameter int WEIGHT  = 15
) (
    input  logic [W-1:0] value,
    output logic [W-1:0] residue
);
    localparam logic [W-1:0] MOD_V = W'(MODULUS);

    logic [W-1:0] first_pass;
    logic [W-1:0] second_pass;

    adler_fold #(.W(W), .HALF_W(HALF_W), .WEIGHT(WEIGHT)) u_pass1 (
        .value  (value),
        .folded (first_pass)
    );

    adler_fold #(.W(W), .HALF_W(HALF_W), .WEIGHT(WEIGHT)) u_pass2 (
        .value  (first_pass),
        .folded (second_pass)
    );

    always_comb begin
        residue = (second_pass >= MOD_V) ? (second_pass - MOD_V) : second_pass;
    end
endmodule

// File: rtl/adler_stream_unit.sv
module adler_stream_unit
    import adler_lazy_pkg::*;
#(
    parameter int ACC_W   = ACC_W_DEF,
    parameter int HALF_W  = HALF_W_DEF,
    parameter int DATA_W  = DATA_W_DEF,
    parameter int MODULUS = MOD_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [DATA_W-1:0]   in_byte,
    input  logic                in_last,
    output logic [2*HALF_W-1:0] sum_out,
    output logic                sum_done
);
    localparam int OUT_W   = 2 * HALF_W;
    localparam int WEIGHT  = fold_weight(HALF_W, MODULUS);
    localparam int LANES   = 2;
    localparam logic [ACC_W-1:0]  ACC_ONE   = ACC_W'(1);
    localparam logic [ACC_W-1:0]  ACC_LIMIT = ACC_ONE << (HALF_W + 1);
    localparam logic [OUT_W-1:0]  EMPTY_SUM = OUT_W'(1);
    localparam logic [HALF_W-1:0] MOD_H     = HALF_W'(MODULUS);

    typedef struct packed {
        logic [ACC_W-1:0] a;       // low sum, lazily reduced
        logic [ACC_W-1:0] b;       // high sum, lazily reduced
        logic             fin;     // last byte taken, exact reduction pending
        logic             done;    // result pulse
        logic [OUT_W-1:0] result;  // registered checksum
    } engine_t;

    engine_t st_q, st_d;

    logic             take;
    logic [ACC_W-1:0] a_step;
    logic [ACC_W-1:0] b_step;
    logic [ACC_W-1:0] lane_in  [LANES];
    logic [ACC_W-1:0] lane_out [LANES];

    assign in_ready = !st_q.fin && !clear;
    assign take     = in_valid && in_ready;
    assign sum_out  = st_q.result;
    assign sum_done = st_q.done;

    adler_step #(
        .ACC_W(ACC_W), .HALF_W(HALF_W), .DATA_W(DATA_W), .WEIGHT(WEIGHT)
    ) u_step (
        .a_cur  (st_q.a),
        .b_cur  (st_q.b),
        .data   (in_byte),
        .a_next (a_step),
        .b_next (b_step)
    );

    assign lane_in[0] = st_q.a;
    assign lane_in[1] = st_q.b;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            adler_reduce #(
                .W(ACC_W), .HALF_W(HALF_W), .MODULUS(MODULUS), .WEIGHT(WEIGHT)
            ) u_reduce (
                .value   (lane_in[g]),
                .residue (lane_out[g])
            );
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (clear) begin
            st_d.a      = ACC_ONE;
            st_d.b      = '0;
            st_d.fin    = 1'b0;
            st_d.result = EMPTY_SUM;
        end else if (st_q.fin) begin
            st_d.result = {lane_out[1][HALF_W-1:0], lane_out[0][HALF_W-1:0]};
            st_d.done   = 1'b1;
            st_d.fin    = 1'b0;
            st_d.a      = ACC_ONE;
            st_d.b      = '0;
        end else if (take) begin
            st_d.a   = a_step;
            st_d.b   = b_step;
            st_d.fin = in_last;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.a      <= ACC_ONE;
            st_q.b      <= '0;
            st_q.fin    <= 1'b0;
            st_q.done   <= 1'b0;
            st_q.result <= EMPTY_SUM;
        end else begin
            st_q <= st_d;
        end
    end

    // R4: the lazy sums never grow past 2^17.
    a_r4_acc_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.a < ACC_LIMIT) && (st_q.b < ACC_LIMIT));

    // R3: the finishing reduction leaves nothing above the low half.
    a_r3_lane_fits: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fin |-> (lane_out[0][ACC_W-1:HALF_W] == '0) && (lane_out[1][ACC_W-1:HALF_W] == '0));

    // R3: each reported half is below the modulus.
    a_r3_halves_below_mod: assert property (@(posedge clk) disable iff (!rst_n)
        sum_done |-> (sum_out[HALF_W-1:0] < MOD_H) && (sum_out[OUT_W-1:HALF_W] < MOD_H));

    // R5: the done pulse lasts one cycle.
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        sum_done |=> !sum_done);

    // R5: the pulse follows the last byte by one edge unless clear intervenes.
    a_r5_done_timing: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_last) ##1 !clear |=> sum_done);

    // R5: the result holds between events.
    a_r5_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> $stable(sum_out) || sum_done);

    // R6: the input stalls right after the last byte.
    a_r6_stall_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_last) |=> !in_ready);

    // R8 and R1: clear restores the empty checksum and suppresses done.
    a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (sum_out == EMPTY_SUM) && !sum_done);
endmodule

// File: tb/adler_stream_unit_bench.sv
module adler_stream_unit_bench;
    localparam int PERIOD   = 10;
    localparam int MEM_SZ   = 8192;
    localparam int MODULUS  = 65521;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_byte = '0;
    logic        in_last = 1'b0;
    logic [31:0] sum_out;
    logic        sum_done;

    logic [7:0]  msg_mem [0:MEM_SZ-1];
    int          n_checks = 0;
    int          n_fails  = 0;

    always #(PERIOD/2) clk = ~clk;

    adler_stream_unit u_adler_stream_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_byte  (in_byte),
        .in_last  (in_last),
        .sum_out  (sum_out),
        .sum_done (sum_done)
    );

    function automatic logic [31:0] ref_sum(input int len);
        int unsigned a = 1;
        int unsigned b = 0;
        for (int i = 0; i < len; i++) begin
            a = (a + 32'(msg_mem[i])) % MODULUS;
            b = (b + a) % MODULUS;
        end
        return {b[15:0], a[15:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    // Send msg_mem[0..len-1]; optional idle gaps carry junk (R7); then check the result.
    task automatic send_msg(input int len, input bit gaps);
        logic [31:0] exp = ref_sum(len);
        logic [31:0] held;
        for (int i = 0; i < len; i++) begin
            if (gaps && ($urandom % 4 == 0)) begin
                in_valid = 1'b0;
                in_byte  = 8'($urandom);
                in_last  = 1'($urandom);
                @(negedge clk);
            end
            while (!in_ready) @(negedge clk);
            in_valid = 1'b1;
            in_byte  = msg_mem[i];
            in_last  = (i == len - 1);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        chk("R6 stall after last", {31'd0, in_ready}, 32'd0);
        chk("R5 no early done", {31'd0, sum_done}, 32'd0);
        @(negedge clk);
        chk("R5 done pulse", {31'd0, sum_done}, 32'd1);
        chk("R2 checksum", sum_out, exp);
        chk("R3 low half below mod", {31'd0, (sum_out[15:0] < 16'(MODULUS))}, 32'd1);
        chk("R3 high half below mod", {31'd0, (sum_out[31:16] < 16'(MODULUS))}, 32'd1);
        chk("R6 ready back", {31'd0, in_ready}, 32'd1);
        held = sum_out;
        @(negedge clk);
        chk("R5 single pulse", {31'd0, sum_done}, 32'd0);
        chk("R5 result held", sum_out, held);
    endtask

    initial begin
        #(PERIOD * 190000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 reset sum", sum_out, 32'h0000_0001);
        chk("R1 reset done", {31'd0, sum_done}, 32'd0);
        chk("R1 reset ready", {31'd0, in_ready}, 32'd1);

        // R1: empty message via clear
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        chk("R1 empty after clear", sum_out, 32'h0000_0001);

        // Single zero byte -> A=1, B=1
        msg_mem[0] = 8'h00;
        send_msg(1, 1'b0);
        chk("R2 single zero byte", sum_out, 32'h0001_0001);

        // R4: long 0xFF run, then long 0x00 run (R9 back to back)
        for (int i = 0; i < 6000; i++) msg_mem[i] = 8'hFF;
        send_msg(6000, 1'b0);
        for (int i = 0; i < 3000; i++) msg_mem[i] = 8'h00;
        send_msg(3000, 1'b0);
        for (int i = 0; i < 8000; i++) msg_mem[i] = 8'hFF;
        send_msg(8000, 1'b1);

        // R2/R7/R9: random messages with junk-filled gaps
        for (int m = 0; m < 30; m++) begin
            int len = 1 + int'($urandom % 400);
            for (int i = 0; i < len; i++) msg_mem[i] = 8'($urandom);
            send_msg(len, 1'b1);
        end

        // R8: clear in the middle of a message while a byte is offered
        for (int i = 0; i < 50; i++) begin
            in_valid = 1'b1;
            in_byte  = 8'($urandom);
            in_last  = 1'b0;
            @(negedge clk);
        end
        clear    = 1'b1;
        in_valid = 1'b1;
        in_byte  = 8'hA5;
        in_last  = 1'b1;
        #1;
        chk("R8 ready low during clear", {31'd0, in_ready}, 32'd0);
        @(negedge clk);
        clear    = 1'b0;
        in_valid = 1'b0;
        in_last  = 1'b0;
        chk("R8 clear restores empty sum", sum_out, 32'h0000_0001);
        chk("R8 clear no done", {31'd0, sum_done}, 32'd0);
        @(negedge clk);
        chk("R8 no done from dropped last", {31'd0, sum_done}, 32'd0);
        for (int i = 0; i < 64; i++) msg_mem[i] = 8'(i * 7 + 3);
        send_msg(64, 1'b1);

        // R8: clear during the reduction cycle cancels completion
        msg_mem[0] = 8'h42;
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_byte  = msg_mem[0];
        in_last  = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        clear    = 1'b1;
        @(negedge clk);
        clear    = 1'b0;
        chk("R8 cancel pending done", {31'd0, sum_done}, 32'd0);
        chk("R8 cancel result empty", sum_out, 32'h0000_0001);

        finish_run();
    end
endmodule